// File: doc/BRIEF.md
# Static RAM strobe sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 16384 four-bit words. The RAM has separate input and output data buses and two active-low chip selects. The host offers one request at a time on a valid/ready handshake. Each request carries a read/write flag, a 14-bit word address and, for writes, a 4-bit word. The sequencer then drives the RAM address, both chip selects, the output enable, the write enable and the input data bus. The strobes are held for whole clock cycles, and each count is derived from nanosecond timing parameters and the clock period.

A write is ended by write enable, and chip select stays low past the point where write enable rises. The address and data are set up with the device selected and write enable high. Write enable is then pulsed low, and the address and data stay unchanged for at least one cycle after write enable returns high. A read holds the device selected with output enable low for the access count. The read word is then registered from the RAM output bus and returned with a single-cycle valid pulse. After a read, any write waits for a number of idle cycles that covers the time the RAM outputs take to float. With no access in progress, both chip selects stay high so the RAM remains in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, both chip selects, output enable and write enable are high, rd_valid is low and req_ready is high.
- R2: Whenever no access is in progress, both chip selects, output enable and write enable are high at the same time. The block accepts a request only in that state.
- R3: Each timing figure in ns becomes a cycle count with cyc(t) = max(1, ceil(t / CLK_NS)). In a write, the chip selects are low with write enable high for at least cyc(T_AS_NS) cycles before write enable falls.
- R4: The write enable low pulse lasts exactly max(cyc(T_WP_NS), cyc(T_DS_NS), cyc(T_AW_NS)) cycles, and output enable stays high for the whole pulse.
- R5: From the cycle the chip selects fall until they rise, the address and input data do not change. The chip selects stay low for at least one cycle after write enable rises, and they stay low for at least cyc(T_WC_NS) cycles in total for a write.
- R6: A read holds chip selects and output enable low, with write enable high, for exactly max(cyc(T_AA_NS), cyc(T_ACS_NS), cyc(T_OE_NS), cyc(T_RC_NS)) cycles after acceptance. rd_valid is a one-cycle pulse that rises in the cycle after that window ends, and output enable is already high in that cycle.
- R7: rd_data, while rd_valid is high, equals the word most recently written to that address. The value is sampled from the RAM output bus at the last clock edge of the read window.
- R8: A write that follows a read is accepted exactly cyc(T_OHZ_NS) cycles after the read window ends. This leaves at least that many idle cycles before its chip selects fall.
- R9: A read that follows a read, and any request that follows a write, is accepted at the first clock edge after the previous access ends. No further idle cycle is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this clock edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 4 | Write word |
| rd_data | output | 4 | Read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_addr | output | 14 | RAM address lines |
| mem_cs1_n | output | 1 | RAM chip select 1, active low |
| mem_cs2_n | output | 1 | RAM chip select 2, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_din | output | 4 | RAM input data bus |
| mem_dout | input | 4 | RAM output data bus |

## Verification
A request accepted at clock edge A has fixed timing. A read drives rd_valid during the cycle after edge A plus the read count. A write drops write enable at A plus the setup count plus one edge. A write queued behind a read is accepted the turnaround count of edges after the read window closes. The bench records the edge of acceptance and stores the expected word with its due cycle in a queue. The monitor compares the word and the due cycle when rd_valid appears. The RAM model counts strobe widths in cycles and offers valid output data only once the read access count has elapsed, so a read that samples too early sees unknown data.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the static RAM strobe sequencer.
// Assumes all timing figures are whole nanoseconds and positive clock period.
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_READ
    } seq_state_t;

    // Round a ns figure up to clock cycles, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned cmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down counter that times one strobe phase.
// Loading value N-1 makes done high for the N-th cycle of the phase.
// Assumes load is only used while done is high or at the phase start.
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Registers the RAM output word and flags it with a one-cycle pulse.
// Assumes capture is high for exactly one cycle per read.
module sram_rd_capture #(
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dvalid
);

    // Sample the bus on the capture edge and raise the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= capture;
            if (capture)
                dout <= din;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
// Static RAM strobe sequencer: turns host read/write requests into
// write-enable-ended write cycles and timed read cycles for an
// asynchronous RAM with split data buses and two active-low selects.
// Assumes a single request in flight; timing figures are in ns and are
// rounded up to cycles of CLK_NS.
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned DATA_W   = 4,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_AS_NS  = 0,
    parameter int unsigned T_WP_NS  = 12,
    parameter int unsigned T_DS_NS  = 7,
    parameter int unsigned T_AW_NS  = 12,
    parameter int unsigned T_WC_NS  = 15,
    parameter int unsigned T_AA_NS  = 15,
    parameter int unsigned T_ACS_NS = 15,
    parameter int unsigned T_OE_NS  = 10,
    parameter int unsigned T_RC_NS  = 15,
    parameter int unsigned T_OHZ_NS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_din,
    input  logic [DATA_W-1:0] mem_dout
);

    localparam int unsigned N_WSU  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int unsigned N_WP   = cmax(ns_to_cyc(T_WP_NS, CLK_NS),
                                          cmax(ns_to_cyc(T_DS_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)));
    localparam int unsigned N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned N_WH   = (N_WC > N_WSU + N_WP + 1) ? (N_WC - N_WSU - N_WP) : 1;
    localparam int unsigned N_RA   = cmax(cmax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_ACS_NS, CLK_NS)),
                                          cmax(ns_to_cyc(T_OE_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)));
    localparam int unsigned N_TURN = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int unsigned N_MAX  = cmax(cmax(N_WSU, N_WP), cmax(cmax(N_WH, N_RA), N_TURN));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    localparam logic [CW-1:0] LD_WSU  = CW'(N_WSU - 1);
    localparam logic [CW-1:0] LD_WP   = CW'(N_WP - 1);
    localparam logic [CW-1:0] LD_WH   = CW'(N_WH - 1);
    localparam logic [CW-1:0] LD_RA   = CW'(N_RA - 1);
    localparam logic [CW-1:0] LD_TURN = CW'(N_TURN - 1);

    seq_state_t        state, nxt_state;
    logic              accept;
    logic              ph_load, ph_done;
    logic [CW-1:0]     ph_val;
    logic              gap_load, gap_done;
    logic              cap;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;

    // Phase length timer shared by all write and read phases.
    sram_phase_timer #(.CW(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    // Output-float turnaround timer started when a read ends.
    sram_phase_timer #(.CW(CW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (LD_TURN),
        .done     (gap_done)
    );

    // Read word register and valid pulse.
    sram_rd_capture #(.DW(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .din     (mem_dout),
        .dout    (rd_data),
        .dvalid  (rd_valid)
    );

    // Ready only when idle, and writes wait for the turnaround to finish.
    assign req_ready = (state == ST_IDLE) && (!req_write || gap_done);
    assign accept    = req_valid && req_ready;

    // Next-state and timer-load decode for the access sequence.
    always_comb begin
        nxt_state = state;
        ph_load   = 1'b0;
        ph_val    = '0;
        gap_load  = 1'b0;
        cap       = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    ph_load = 1'b1;
                    if (req_write) begin
                        nxt_state = ST_WSETUP;
                        ph_val    = LD_WSU;
                    end else begin
                        nxt_state = ST_READ;
                        ph_val    = LD_RA;
                    end
                end
            end
            ST_WSETUP: begin
                if (ph_done) begin
                    nxt_state = ST_WPULSE;
                    ph_load   = 1'b1;
                    ph_val    = LD_WP;
                end
            end
            ST_WPULSE: begin
                if (ph_done) begin
                    nxt_state = ST_WHOLD;
                    ph_load   = 1'b1;
                    ph_val    = LD_WH;
                end
            end
            ST_WHOLD: begin
                if (ph_done)
                    nxt_state = ST_IDLE;
            end
            ST_READ: begin
                if (ph_done) begin
                    nxt_state = ST_IDLE;
                    cap       = 1'b1;
                    gap_load  = 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    // Latch address and write word on acceptance; they stay put for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            din_q  <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            din_q  <= req_wdata;
        end
    end

    // Strobes decoded from the registered state.
    assign mem_cs1_n = (state == ST_IDLE);
    assign mem_cs2_n = (state == ST_IDLE);
    assign mem_oe_n  = (state != ST_READ);
    assign mem_we_n  = (state != ST_WPULSE);
    assign mem_addr  = addr_q;
    assign mem_din   = din_q;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the static RAM strobe sequencer, bound to the top.
// Assumes synchronous active-low reset held for at least one clock.
module sram_seq_ctrl_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_din
);

    // R2: a request can only be taken while the RAM is deselected.
    assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && mem_cs2_n && mem_oe_n && mem_we_n));

    // R3: write enable falls only after a cycle with the device selected.
    assert_we_after_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && !mem_cs2_n && $past(!mem_cs1_n) && $past(!mem_cs2_n)));

    // R4: output enable stays off during the write pulse.
    assert_no_oe_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5: address and data stay stable through the pulse and the hold cycle.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

    // R5: selects remain low in the cycle write enable rises.
    assert_hold_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs1_n && !mem_cs2_n));

    // R6: rd_valid is a single-cycle pulse.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: output enable is already off when the word is returned.
    assert_valid_after_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_oe_n && $past(!mem_oe_n)));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2_n (mem_cs2_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_din   (mem_din)
);

// File: tb/sram_seq_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench with a cycle-level RAM model for the strobe sequencer.
module sram_seq_ctrl_tb;

    localparam int CLK_PERIOD = 5;
    localparam int AW = 14;
    localparam int DW = 4;

    // Expected counts from the requirement formulas.
    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_WSU  = cyc(0);
    localparam int E_WP   = mx(cyc(12), mx(cyc(7), cyc(12)));
    localparam int E_WC   = cyc(15);
    localparam int E_RA   = mx(mx(cyc(15), cyc(15)), mx(cyc(10), cyc(15)));
    localparam int E_TURN = cyc(15);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] mem_din;
    logic [DW-1:0] mem_dout = 'x;

    int checks = 0;
    int errors = 0;
    int cyc_n  = 0;
    bit done   = 0;

    typedef struct {
        logic [DW-1:0] data;
        int            due;
        int            addr;
    } exp_t;
    exp_t exp_q[$];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] ram_m  [int];

    sram_seq_ctrl #(.CLK_NS(CLK_PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2_n(mem_cs2_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_n);
        end
    endtask

    // RAM model: counts strobe widths at mid-cycle and serves reads after the access count.
    logic          prev_cs = 0, prev_we_low = 0, prev_rd = 0, wr_seen = 0, last_rd = 0;
    int            we_cnt = 0, setup_cnt = 0, cs_cnt = 0, idle_cnt = 0, gap_seen = 0, age = 0, prev_age = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_din = '0;
    always @(negedge clk) begin
        logic cs_act, rd_cond;
        if (rst_n) begin
            cs_act  = !mem_cs1_n && !mem_cs2_n;
            rd_cond = cs_act && !mem_oe_n && mem_we_n;
            if (cs_act) begin
                if (!prev_cs) begin
                    gap_seen = idle_cnt; setup_cnt = 0; wr_seen = 0; cs_cnt = 0;
                end else begin
                    chk(mem_addr == prev_addr && mem_din == prev_din, "R5 addr/data stable", int'(mem_addr), int'(prev_addr));
                end
                idle_cnt = 0;
                cs_cnt++;
                if (mem_we_n && !prev_we_low && !wr_seen) setup_cnt++;
                if (!mem_we_n) begin
                    if (!prev_we_low) begin
                        chk(setup_cnt >= E_WSU, "R3 setup", setup_cnt, E_WSU);
                        if (last_rd) chk(gap_seen >= E_TURN, "R8 idle gap", gap_seen, E_TURN);
                        last_rd = 0; we_cnt = 0; wr_seen = 1;
                    end
                    we_cnt++;
                    chk(mem_oe_n, "R4 oe off in write", int'(mem_oe_n), 1);
                end else if (prev_we_low) begin
                    chk(we_cnt == E_WP, "R4 we width", we_cnt, E_WP);
                    ram_m[int'(mem_addr)] = mem_din;
                end
            end else begin
                if (prev_cs) begin
                    if (wr_seen) chk(cs_cnt >= E_WC, "R5 write cycle", cs_cnt, E_WC);
                    else begin
                        chk(prev_age == E_RA, "R6 oe window", prev_age, E_RA);
                        last_rd = 1;
                    end
                end
                chk(!prev_we_low, "R5 select kept past we", int'(prev_we_low), 0);
                chk(mem_cs1_n && mem_cs2_n && mem_oe_n && mem_we_n, "R2 standby",
                    int'({mem_cs1_n, mem_cs2_n, mem_oe_n, mem_we_n}), 15);
                idle_cnt++;
            end
            if (rd_cond && prev_rd && mem_addr == prev_addr) age++;
            else if (rd_cond) age = 1;
            else age = 0;
            if (rd_cond && age >= E_RA)
                mem_dout <= ram_m.exists(int'(mem_addr)) ? ram_m[int'(mem_addr)] : '0;
            else
                mem_dout <= 'x;
            prev_age    = age;
            prev_rd     = rd_cond;
            prev_cs     = cs_act;
            prev_we_low = cs_act && !mem_we_n;
            prev_addr   = mem_addr;
            prev_din    = mem_din;
        end
    end

    // Monitor: pops the scoreboard whenever a read word is returned.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected rd_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rd_data === e.data, "R7 read data", int'(rd_data), int'(e.data));
                chk(cyc_n == e.due, "R6 read latency", cyc_n, e.due);
            end
        end
    end

    // Driver: present a request from a negedge and return the accepting edge.
    task automatic issue(input bit wr, input int addr, input int data, output int acc);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = DW'(data);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc_n + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input int addr, input int data, output int acc);
        issue(1'b1, addr, data, acc);
        shadow[addr] = DW'(data);
    endtask

    task automatic do_read(input int addr, output int acc);
        exp_t e;
        issue(1'b0, addr, 0, acc);
        e.data = shadow.exists(addr) ? shadow[addr] : '0;
        e.due  = acc + E_RA;
        e.addr = addr;
        exp_q.push_back(e);
    endtask

    initial begin
        int a0, a1, a2;
        repeat (4) @(negedge clk);
        // R1: reset values while reset is held.
        chk(mem_cs1_n && mem_cs2_n && mem_oe_n && mem_we_n, "R1 strobes in reset",
            int'({mem_cs1_n, mem_cs2_n, mem_oe_n, mem_we_n}), 15);
        chk(!rd_valid, "R1 rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_valid && mem_cs1_n && mem_cs2_n, "R1 after reset", int'(req_ready), 1);

        // Write after write: back-to-back spacing (R9).
        do_write(0, 5, a0);
        do_write(16383, 10, a1);
        chk(a1 == a0 + E_WSU + E_WP + 1 + 1, "R9 write-write spacing", a1 - a0, E_WSU + E_WP + 2);
        do_write(16'h1555, 15, a0);
        do_write(16'h2AAA, 0, a0);

        // Read after read: no extra gap (R9).
        do_read(0, a0);
        do_read(16383, a1);
        chk(a1 == a0 + E_RA + 1, "R9 read-read spacing", a1 - a0, E_RA + 1);
        // Write after read: turnaround (R8).
        do_write(0, 9, a2);
        chk(a2 == a1 + E_RA + E_TURN, "R8 write after read", a2 - a1, E_RA + E_TURN);
        do_read(0, a0);
        do_read(16'h1555, a0);
        do_read(16'h2AAA, a0);

        // Several address/data patterns, interleaved (R7).
        for (int i = 0; i < 8; i++) begin
            do_write((i * 16'h0801) & 16'h3FFF, (i * 3 + 1) & 15, a0);
        end
        for (int i = 7; i >= 0; i--) begin
            do_read((i * 16'h0801) & 16'h3FFF, a0);
        end
        for (int i = 0; i < 4; i++) begin
            do_write(16'h0100 + i, 15 - i, a0);
            do_read(16'h0100 + i, a0);
        end

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        chk(mem_cs1_n && mem_cs2_n, "R2 standby at end", int'({mem_cs1_n, mem_cs2_n}), 3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule